// File: doc/BRIEF.md
# Adaptive Binary Arithmetic Bit Decoder

This block turns a compressed byte stream back into single bits, one bit per request. Each request names a context. The context holds a small probability state and a guess of the likely bit value, which is called the MPS. The decoder takes the current state's probability of the unlikely bit (the LPS) away from an 8-bit range. It compares the top byte of a 16-bit input window against what is left of the range. From that comparison it picks the bit, then updates the context. The probability machine is fixed: 53 states in five groups. Each state has a probability entry, an MPS successor and an LPS successor.

After each decision the range is doubled with a one shifted in, one step per clock, until it is back at 127 or above. Each step shifts the input window left by one bit. When only eight unconsumed bits remain, the next byte is pulled in over a valid/ready handshake, and the decoder waits while no byte is offered. The surrounding logic builds the context index from earlier bits and packs the bits into bytes. A `start_i` pulse begins a new stream: it resets every context, loads the range and fills the window with two bytes.

FSM states: `ST_OFF` (no stream yet), `ST_FILL_HI` and `ST_FILL_LO` (priming the window), `ST_IDLE` (ready for a request) and `ST_SHIFT` (renormalising, possibly stalled on a fetch). Transitions:
- start (any state to `ST_FILL_HI`)
- hi_loaded (`ST_FILL_HI` to `ST_FILL_LO`)
- lo_loaded (`ST_FILL_LO` to `ST_IDLE`)
- decide_low (`ST_IDLE` to `ST_SHIFT`, when the reduced range is below 127)
- decide_ok (`ST_IDLE` stays in `ST_IDLE`)
- shift_more (stays in `ST_SHIFT`)
- shift_done (`ST_SHIFT` to `ST_IDLE`)

Top module: `adc_decoder`

## Requirements
- R1: Before the first start pulse, `idle_o`, `byte_ready_o` and `done_o` stay low, and `req_i` is ignored (no `done_o`).
- R2: A start pulse resets every context to state 0 with MPS 0 and sets the range to 255. It then takes exactly two bytes, the first into the high byte of the window and the second into the low byte, and then raises `idle_o`.
- R3: A request takes the state's LPS probability (53-entry table) away from the range. If the window's high byte is greater than the result, `bit_o` is the inverted MPS; otherwise `bit_o` is the MPS.
- R4: On an LPS, the window's high byte drops by (reduced range + 1) and the low byte is kept. The MPS flips if the reduced range exceeds 79. The state moves to its LPS successor.
- R5: On an MPS, the state moves to its MPS successor only if the reduced range is below 127; otherwise it is kept.
- R6: Renormalisation takes one clock per step. Each step sets the range to (range<<1)|1 and shifts the window left. When bytes are always offered, `done_o` rises exactly 1 + steps cycles after the request edge.
- R7: `byte_ready_o` is high during renormalisation only when exactly 8 unconsumed bits remain. The byte goes into the window's low byte before that step's shift. Without `byte_valid_i` the decoder holds its range and does not finish.
- R8: `done_o` is raised with `bit_o` valid only on a return to `ST_IDLE`, with the range at 127 or above.
- R9: Each of the NCTX contexts (default 32) keeps its own state and MPS. A decode only touches the context named by `ctx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new stream |
| ctx_i | input | CW | Context index for the request |
| req_i | input | 1 | Decode request, taken in `ST_IDLE` |
| byte_i | input | 8 | Compressed input byte |
| byte_valid_i | input | 1 | `byte_i` is offered |
| byte_ready_o | output | 1 | Decoder takes a byte this cycle if offered |
| idle_o | output | 1 | Ready for a request |
| bit_o | output | 1 | Decoded bit, valid with `done_o` |
| done_o | output | 1 | Decode finished |

## Verification
On every cycle, the assertions check several things:
- the range floor while idle
- the doubling-with-one step during renormalisation
- range hold and absent completion during a fetch stall
- the bounds of the bit counter
- that a byte is never requested while idle

Only the bench scenarios can show that whole decoded sequences are correct. The bench compares them against an arithmetic model. These sequences cover:
- the probability and successor tables
- the MPS flip threshold
- independence of the contexts
- restarting a stream
- fetch latency with and without gaps in the input stream

// File: rtl/adc_pkg.sv
package adc_pkg;
    localparam int NSTATE = 53;
    typedef logic [5:0] st_idx_t;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_FILL_HI,
        ST_FILL_LO,
        ST_IDLE,
        ST_SHIFT
    } fsm_t;

    localparam logic [7:0] RANGE_INIT  = 8'd255;
    localparam logic [7:0] RANGE_FLOOR = 8'd127;
    localparam logic [7:0] SWAP_LIMIT  = 8'd79;
    localparam logic [4:0] CNT_FULL    = 5'd16;
    localparam logic [4:0] CNT_REFILL  = 5'd8;

    // LPS probability per state, five groups starting at 0, 6, 19, 39, 47
    localparam logic [6:0] PROB_TAB [NSTATE] = '{
        7'd90, 7'd37, 7'd17, 7'd8,  7'd3,  7'd1,
        7'd90, 7'd63, 7'd44, 7'd32, 7'd23, 7'd17, 7'd12, 7'd9,  7'd7,  7'd5,  7'd4,  7'd3,  7'd2,
        7'd90, 7'd72, 7'd58, 7'd46, 7'd38, 7'd31, 7'd25, 7'd21, 7'd17, 7'd14, 7'd11, 7'd9,  7'd8,
        7'd7,  7'd5,  7'd4,  7'd4,  7'd3,  7'd2,  7'd2,
        7'd88, 7'd77, 7'd67, 7'd59, 7'd52, 7'd46, 7'd41, 7'd37,
        7'd86, 7'd79, 7'd71, 7'd65, 7'd60, 7'd55
    };

    localparam logic [5:0] NEXT_ON_MPS [NSTATE] = '{
        6'd1,  6'd2,  6'd3,  6'd4,  6'd5,  6'd5,
        6'd7,  6'd8,  6'd9,  6'd10, 6'd11, 6'd12, 6'd13, 6'd14, 6'd15, 6'd16, 6'd17, 6'd18, 6'd5,
        6'd20, 6'd21, 6'd22, 6'd23, 6'd24, 6'd25, 6'd26, 6'd27, 6'd28, 6'd29, 6'd30, 6'd31, 6'd32,
        6'd33, 6'd34, 6'd35, 6'd36, 6'd37, 6'd38, 6'd5,
        6'd40, 6'd41, 6'd42, 6'd43, 6'd44, 6'd45, 6'd46, 6'd24,
        6'd48, 6'd49, 6'd50, 6'd51, 6'd52, 6'd43
    };

    localparam logic [5:0] NEXT_ON_LPS [NSTATE] = '{
        6'd1,  6'd6,  6'd8,  6'd10, 6'd12, 6'd15,
        6'd7,  6'd19, 6'd21, 6'd22, 6'd23, 6'd25, 6'd26, 6'd28, 6'd29, 6'd31, 6'd32, 6'd34, 6'd35,
        6'd20, 6'd39, 6'd40, 6'd42, 6'd44, 6'd45, 6'd46, 6'd25, 6'd26, 6'd26, 6'd27, 6'd28, 6'd29,
        6'd30, 6'd31, 6'd33, 6'd33, 6'd34, 6'd35, 6'd36,
        6'd39, 6'd47, 6'd48, 6'd49, 6'd50, 6'd51, 6'd44, 6'd45,
        6'd47, 6'd47, 6'd48, 6'd49, 6'd50, 6'd51
    };
endpackage

// File: rtl/adc_tables.sv
module adc_tables
    import adc_pkg::*;
(
    input  st_idx_t    st_i,
    output logic [6:0] prob_o,
    output st_idx_t    nxt_mps_o,
    output st_idx_t    nxt_lps_o
);
    always_comb begin
        prob_o    = PROB_TAB[st_i];
        nxt_mps_o = NEXT_ON_MPS[st_i];
        nxt_lps_o = NEXT_ON_LPS[st_i];
    end
endmodule

// File: rtl/adc_ctx_store.sv
module adc_ctx_store
    import adc_pkg::*;
#(
    parameter  int NCTX = 32,
    localparam int CW   = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [CW-1:0] ctx_i,
    input  logic          wr_en_i,
    input  st_idx_t       wr_st_i,
    input  logic          wr_mps_i,
    output st_idx_t       rd_st_o,
    output logic          rd_mps_o
);
    st_idx_t st_arr  [NCTX];
    logic    mps_arr [NCTX];

    for (genvar g = 0; g < NCTX; g++) begin : g_ctx
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_arr[g]  <= '0;
                mps_arr[g] <= 1'b0;
            end else if (clr_i) begin
                st_arr[g]  <= '0;
                mps_arr[g] <= 1'b0;
            end else if (wr_en_i && ctx_i == CW'(g)) begin
                st_arr[g]  <= wr_st_i;
                mps_arr[g] <= wr_mps_i;
            end
        end
    end

    assign rd_st_o  = st_arr[ctx_i];
    assign rd_mps_o = mps_arr[ctx_i];
endmodule

// File: rtl/adc_decoder.sv
module adc_decoder
    import adc_pkg::*;
#(
    parameter  int NCTX = 32,
    localparam int CW   = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] ctx_i,
    input  logic          req_i,
    input  logic [7:0]    byte_i,
    input  logic          byte_valid_i,
    output logic          byte_ready_o,
    output logic          idle_o,
    output logic          bit_o,
    output logic          done_o
);
    fsm_t        state_q, state_d;
    logic [7:0]  range_q;
    logic [15:0] win_q;
    logic [4:0]  cnt_q;
    logic        bit_q, done_q;

    st_idx_t     ctx_st, nxt_mps, nxt_lps, upd_st;
    logic        ctx_mps, upd_mps;
    logic [6:0]  prob;

    logic        accept, is_lps, dec_bit;
    logic [7:0]  r_sub, range_sh;
    logic        need_byte, stall;
    logic [15:0] win_fed;

    adc_ctx_store #(.NCTX(NCTX)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (start_i),
        .ctx_i    (ctx_i),
        .wr_en_i  (accept && !start_i),
        .wr_st_i  (upd_st),
        .wr_mps_i (upd_mps),
        .rd_st_o  (ctx_st),
        .rd_mps_o (ctx_mps)
    );

    adc_tables i_tables (
        .st_i      (ctx_st),
        .prob_o    (prob),
        .nxt_mps_o (nxt_mps),
        .nxt_lps_o (nxt_lps)
    );

    // Decision path: range reduction, compare, context update
    always_comb begin
        accept  = (state_q == ST_IDLE) && req_i;
        r_sub   = range_q - {1'b0, prob};
        is_lps  = win_q[15:8] > r_sub;
        dec_bit = ctx_mps ^ is_lps;
        if (is_lps) begin
            upd_st  = nxt_lps;
            upd_mps = ctx_mps ^ (r_sub > SWAP_LIMIT);
        end else begin
            upd_st  = (r_sub < RANGE_FLOOR) ? nxt_mps : ctx_st;
            upd_mps = ctx_mps;
        end
    end

    // Renormalisation path
    always_comb begin
        need_byte = (cnt_q == CNT_REFILL);
        stall     = (state_q == ST_SHIFT) && need_byte && !byte_valid_i;
        win_fed   = need_byte ? {win_q[15:8], byte_i} : win_q;
        range_sh  = {range_q[6:0], 1'b1};
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:     state_d = ST_OFF;
            ST_FILL_HI: if (byte_valid_i) state_d = ST_FILL_LO;
            ST_FILL_LO: if (byte_valid_i) state_d = ST_IDLE;
            ST_IDLE:    if (req_i && r_sub < RANGE_FLOOR) state_d = ST_SHIFT;
            ST_SHIFT:   if (!stall && range_sh >= RANGE_FLOOR) state_d = ST_IDLE;
            default:    state_d = ST_OFF;
        endcase
        if (start_i) state_d = ST_FILL_HI;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            range_q <= RANGE_INIT;
            win_q   <= '0;
            cnt_q   <= CNT_FULL;
            bit_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                range_q <= RANGE_INIT;
                win_q   <= '0;
                cnt_q   <= CNT_FULL;
            end else begin
                unique case (state_q)
                    ST_FILL_HI: if (byte_valid_i) win_q[15:8] <= byte_i;
                    ST_FILL_LO: if (byte_valid_i) win_q[7:0]  <= byte_i;
                    ST_IDLE: if (req_i) begin
                        range_q <= r_sub;
                        bit_q   <= dec_bit;
                        if (is_lps) win_q[15:8] <= win_q[15:8] - r_sub - 8'd1;
                        if (r_sub >= RANGE_FLOOR) done_q <= 1'b1;
                    end
                    ST_SHIFT: if (!stall) begin
                        range_q <= range_sh;
                        win_q   <= {win_fed[14:0], 1'b0};
                        cnt_q   <= need_byte ? (CNT_FULL - 5'd1) : (cnt_q - 5'd1);
                        if (range_sh >= RANGE_FLOOR) done_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign byte_ready_o = (state_q == ST_FILL_HI) || (state_q == ST_FILL_LO) ||
                          ((state_q == ST_SHIFT) && need_byte);
    assign idle_o = (state_q == ST_IDLE);
    assign bit_o  = bit_q;
    assign done_o = done_q;
endmodule

// File: rtl/adc_decoder_chk.sv
module adc_decoder_chk
    import adc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input fsm_t       state_q,
    input logic [7:0] range_q,
    input logic [4:0] cnt_q,
    input logic       byte_valid_i,
    input logic       byte_ready_o,
    input logic       idle_o,
    input logic       done_o
);
    a_r8_range_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (range_q >= RANGE_FLOOR));

    a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> idle_o);

    a_r6_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !start_i && !(cnt_q == CNT_REFILL && !byte_valid_i))
        |=> (range_q == {$past(range_q[6:0]), 1'b1}));

    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !start_i && cnt_q == CNT_REFILL && !byte_valid_i)
        |=> ($stable(range_q) && !done_o));

    a_r7_no_fetch_idle: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> !idle_o);

    a_r7_cnt_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= CNT_REFILL) && (cnt_q <= CNT_FULL));

    a_r1_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (!byte_ready_o && !done_o));
endmodule

bind adc_decoder adc_decoder_chk i_adc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .state_q      (state_q),
    .range_q      (range_q),
    .cnt_q        (cnt_q),
    .byte_valid_i (byte_valid_i),
    .byte_ready_o (byte_ready_o),
    .idle_o       (idle_o),
    .done_o       (done_o)
);

// File: tb/test_adc_decoder.sv
module test_adc_decoder;
    localparam int NCTX  = 32;
    localparam int CW    = 5;
    localparam int NBITS = 240;
    localparam int SLEN  = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] ctx_i = '0;
    logic          req_i = 1'b0;
    logic [7:0]    byte_i = 8'd0;
    logic          byte_valid_i = 1'b0;
    logic          byte_ready_o, idle_o, bit_o, done_o;

    always #2 clk = ~clk;

    adc_decoder #(.NCTX(NCTX)) i_adc_decoder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctx_i(ctx_i), .req_i(req_i),
        .byte_i(byte_i), .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
        .idle_o(idle_o), .bit_o(bit_o), .done_o(done_o)
    );

    int m_prob [53] = '{90,37,17,8,3,1, 90,63,44,32,23,17,12,9,7,5,4,3,2,
        90,72,58,46,38,31,25,21,17,14,11,9,8,7,5,4,4,3,2,2,
        88,77,67,59,52,46,41,37, 86,79,71,65,60,55};
    int m_nm [53] = '{1,2,3,4,5,5, 7,8,9,10,11,12,13,14,15,16,17,18,5,
        20,21,22,23,24,25,26,27,28,29,30,31,32,33,34,35,36,37,38,5,
        40,41,42,43,44,45,46,24, 48,49,50,51,52,43};
    int m_nl [53] = '{1,6,8,10,12,15, 7,19,21,22,23,25,26,28,29,31,32,34,35,
        20,39,40,42,44,45,46,25,26,26,27,28,29,30,31,33,33,34,35,36,
        39,47,48,49,50,51,44,45, 47,47,48,49,50,51};

    logic [7:0] stream [SLEN];
    int ptr = 0, gap = 0, wait_cnt = 0;
    bit acc_pending = 0;
    int total = 0, bad = 0;

    int m_st [NCTX];
    int m_mps [NCTX];
    int m_rng, m_win, m_cnt, m_ptr;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Byte source: one negedge after an accepted byte, advance and pause for gap cycles
    initial begin
        forever begin
            @(negedge clk);
            if (acc_pending) begin
                ptr++;
                wait_cnt = gap;
            end
            byte_valid_i = (wait_cnt == 0);
            if (wait_cnt > 0) wait_cnt--;
            byte_i = stream[ptr % SLEN];
            acc_pending = byte_valid_i && byte_ready_o;
        end
    end

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic gen_stream(input int kind, input int unsigned seed);
        int unsigned s = seed;
        for (int i = 0; i < SLEN; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            case (kind)
                0: stream[i] = 8'h00;
                1: stream[i] = 8'hFF;
                2: stream[i] = (i % 2 == 0) ? 8'h55 : 8'hAA;
                default: stream[i] = s[23:16];
            endcase
        end
    endtask

    task automatic model_decode(input int c, output int b, output int steps);
        int r = m_rng - m_prob[m_st[c]];
        int hi = (m_win >> 8) & 255;
        if (hi > r) begin
            b = m_mps[c] ^ 1;
            m_win = ((hi - r - 1) << 8) | (m_win & 255);
            if (r > 79) m_mps[c] ^= 1;
            m_st[c] = m_nl[m_st[c]];
        end else begin
            b = m_mps[c];
            if (r < 127) m_st[c] = m_nm[m_st[c]];
        end
        steps = 0;
        while (r < 127) begin
            if (m_cnt == 8) begin
                m_win = m_win | int'(stream[m_ptr % SLEN]);
                m_ptr++;
                m_cnt = 16;
            end
            r = ((r << 1) | 1) & 255;
            m_win = (m_win << 1) & 16'hFFFF;
            m_cnt--;
            steps++;
        end
        m_rng = r;
    endtask

    task automatic start_stream();
        int cyc = 0;
        @(negedge clk);
        ptr = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!idle_o && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        #1;
        check(idle_o == 1'b1, "R2 idle after priming", idle_o, 1);
        check(ptr == 2, "R2 two bytes taken", ptr, 2);
        for (int i = 0; i < NCTX; i++) begin
            m_st[i] = 0;
            m_mps[i] = 0;
        end
        m_rng = 255;
        m_win = (int'(stream[0]) << 8) | int'(stream[1]);
        m_cnt = 16;
        m_ptr = 2;
    endtask

    task automatic decode_one(input int c, output int got);
        int eb, steps, cyc;
        model_decode(c, eb, steps);
        @(negedge clk);
        ctx_i = CW'(c);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        got = int'(bit_o);
        check(bit_o == eb[0], "R3 R4 R5 R9 decoded bit", got, eb);
        check(idle_o == 1'b1, "R8 idle with done", idle_o, 1);
        if (gap == 0) check(cyc == 1 + steps, "R6 latency", cyc, 1 + steps);
        #1;
        check(ptr == m_ptr, "R7 bytes consumed", ptr, m_ptr);
    endtask

    initial begin
        int got, hist, c, seen;
        gen_stream(3, 7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(idle_o == 1'b0, "R1 idle low before start", idle_o, 0);
        check(byte_ready_o == 1'b0, "R1 no byte request before start", byte_ready_o, 0);
        check(done_o == 1'b0, "R1 done low after reset", done_o, 0);
        req_i = 1'b1;
        seen = 0;
        repeat (6) begin
            @(negedge clk);
            if (done_o || byte_ready_o) seen++;
        end
        req_i = 1'b0;
        check(seen == 0, "R1 request ignored before start", seen, 0);

        for (int run = 0; run < 10; run++) begin
            gen_stream(run % 5, 32'd100 + 32'(run));
            gap = (run % 2 == 1) ? 3 : 0;
            start_stream();
            hist = 0;
            for (int n = 0; n < NBITS; n++) begin
                case (run % 3)
                    0: c = 0;
                    1: c = n % NCTX;
                    default: c = hist & (NCTX - 1);
                endcase
                decode_one(c, got);
                hist = (hist << 1) | got;
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule